// File: doc/BRIEF.md
# Synchronization Status Byte Monitor

This block watches the synchronization status byte that a framer pulls out of each received SONET frame. One byte arrives per frame, qualified by a frame strobe. The monitor keeps a filtered copy of the byte, called the accepted byte. A new value replaces it only after that value has persisted. The accepted value then raises a maskable change interrupt. The lower nibble of the accepted byte is decoded into a clock-quality code for the rest of the chip.

A second path judges the stability of the incoming stream. Over a sliding window of the last eight strobes it counts how many bytes disagree with the accepted value. If two or more disagree, an unstable flag is raised, together with its own maskable interrupt. The flag is released only after a run of eight identical bytes. That run may repeat the accepted value or carry a new one.

On the transmit side, a software register supplies the status byte to be inserted into outgoing frames. A small write/read port reaches that register, the accepted byte, the interrupt status and the interrupt enables. Interrupt status bits are sticky and are cleared by a read.

Top module: `sync_status_monitor`

## Requirements
- R1: After reset the accepted byte is 00h and the unstable flag is 1. Both pending bits, both enables, the transmit byte and `irq` are 0.
- R2: The accepted byte takes a new value only when that same value, different from the current accepted byte, has arrived on 8 consecutive strobes. Seven strobes leave it unchanged.
- R3: Any strobe whose byte differs from the byte of the previous strobe restarts the run of identical bytes.
- R4: When the accepted byte changes, the change pending bit (status bit 0) is set.
- R5: The unstable flag is set when 2 or more of the last 8 strobed bytes differ from the accepted byte. A single disagreeing byte in that window does not set it.
- R6: A 0-to-1 transition of the unstable flag sets the unstable pending bit (status bit 1). Status bit 2 reads the live unstable flag.
- R7: The unstable flag clears on the 8th consecutive identical byte, whether or not that byte equals the old accepted value.
- R8: Clock cycles without a strobe change neither the accepted byte nor the unstable state, whatever `rx_byte` carries.
- R9: A read of address 2 returns the status and clears both pending bits. A further read returns them as 0.
- R10: `irq` is the OR of the pending bits ANDed with the enable register (address 3: bit 0 change, bit 1 unstable).
- R11: A write to address 0 sets `tx_byte` and reads back from address 0. Writes to addresses 1 and 2 have no effect. Address 1 reads the accepted byte.
- R12: `qual_code` decodes bits [3:0] of the accepted byte as follows:
  - 0001 gives 1 (stratum 1)
  - 0000 gives 2 (unknown)
  - 0111 gives 3 (stratum 2)
  - 1010 gives 4 (stratum 3)
  - 1100 gives 5 (minimum clock)
  - 1111 gives 6 (do not use)
  - 1110 gives 7 (reserved)
  - any other value gives 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe qualifying `rx_byte` once per frame |
| rx_byte | input | 8 | Received status byte |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data, valid one cycle after `rd_en` |
| tx_byte | output | 8 | Status byte for transmit insertion |
| accepted_byte | output | 8 | Filtered received status byte |
| unstable | output | 1 | Live unstable flag |
| qual_code | output | 3 | Decoded clock-quality code |
| irq | output | 1 | Interrupt request |

## Verification
All results of a strobe come from registers loaded on the strobe's own clock edge:
- the accepted byte
- the unstable flag
- the pending bits
- `irq`
- `qual_code`

Read data is also registered on the edge that samples `rd_en`. The bench drives every input on the falling edge. It holds the input for one rising edge and samples at the next falling edge, so each result is read one edge after its stimulus. Run-length boundaries are checked on both sides: after 7 and after 8 strobes, and after 1 and after 2 disagreeing bytes in the window.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_TX   = 2'd0,
        A_ACC  = 2'd1,
        A_STAT = 2'd2,
        A_EN   = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        Q_UNDEF = 3'd0,
        Q_STR1  = 3'd1,
        Q_UNK   = 3'd2,
        Q_STR2  = 3'd3,
        Q_STR3  = 3'd4,
        Q_SMC   = 3'd5,
        Q_DUS   = 3'd6,
        Q_RES   = 3'd7
    } qual_e;

    // bit 1: unstable, bit 0: change
    typedef struct packed {
        logic unst;
        logic chg;
    } irq_vec_t;

    function automatic qual_e decode_quality(input logic [3:0] nib);
        qual_e q;
        case (nib)
            4'b0001: q = Q_STR1;
            4'b0000: q = Q_UNK;
            4'b0111: q = Q_STR2;
            4'b1010: q = Q_STR3;
            4'b1100: q = Q_SMC;
            4'b1111: q = Q_DUS;
            4'b1110: q = Q_RES;
            default: q = Q_UNDEF;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/ssm_persist.sv
module ssm_persist
    import ssm_pkg::*;
#(
    parameter int W       = BYTE_W,
    parameter int PERSIST = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] accepted,
    output logic         run_full,
    output logic         change_evt
);
    localparam int CW = $clog2(PERSIST + 1);

    logic [W-1:0]  last_q, acc_q;
    logic [CW-1:0] run_q, run_nxt;
    logic          same;

    always_comb begin
        same     = (run_q != '0) && (byte_in == last_q);
        if (!same)
            run_nxt = CW'(1);
        else if (run_q == CW'(PERSIST))
            run_nxt = run_q;
        else
            run_nxt = run_q + CW'(1);
        run_full   = strobe && (run_nxt == CW'(PERSIST));
        change_evt = run_full && (byte_in != acc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            run_q  <= '0;
            acc_q  <= '0;
        end else if (strobe) begin
            last_q <= byte_in;
            run_q  <= run_nxt;
            if (change_evt)
                acc_q <= byte_in;
        end
    end

    assign accepted = acc_q;

    // R2: accepted value moves only on a strobe ending a full run
    p_accept_on_full_run_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> ($past(strobe) && $past(run_q) >= CW'(PERSIST - 1)))
        else $error("accepted byte changed without a full run");

    // R3: a run counter value above one implies repeat of previous byte
    p_run_restart_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe) && $past(byte_in) != $past(last_q)) |-> (run_q == CW'(1)))
        else $error("run not restarted on new byte");

    // R8: no strobe, no movement
    p_hold_without_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe) |-> ($stable(acc_q) && $stable(run_q)))
        else $error("state moved without strobe");

endmodule

// File: rtl/ssm_window.sv
module ssm_window
    import ssm_pkg::*;
#(
    parameter int W       = BYTE_W,
    parameter int WIN     = 8,
    parameter int MIN_BAD = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] byte_in,
    input  logic [W-1:0] ref_byte,
    input  logic         run_full,
    output logic         unstable,
    output logic         unstable_rise
);
    logic [WIN-1:0] hist_q, hist_shift, hist_nxt;
    logic           unst_q, unst_nxt, miss;

    always_comb begin
        miss       = (byte_in != ref_byte);
        hist_shift = {hist_q[WIN-2:0], miss};
        if (run_full) begin
            // the whole window now equals the new accepted value
            hist_nxt = '0;
            unst_nxt = 1'b0;
        end else begin
            hist_nxt = hist_shift;
            unst_nxt = unst_q || ($countones(hist_shift) >= MIN_BAD);
        end
        unstable_rise = strobe && unst_nxt && !unst_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            unst_q <= 1'b1;
        end else if (strobe) begin
            hist_q <= hist_nxt;
            unst_q <= unst_nxt;
        end
    end

    assign unstable = unst_q;

    // R5: flag rises only with enough disagreements in the window
    p_rise_needs_count_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(unst_q) |-> ($countones(hist_q) >= MIN_BAD))
        else $error("unstable rose with too few mismatches");

    // R7: flag falls only on a completed run
    p_fall_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(unst_q) |-> $past(run_full))
        else $error("unstable fell without a full run");

endmodule

// File: rtl/ssm_regs.sv
module ssm_regs
    import ssm_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      accepted,
    input  logic              unstable,
    input  logic              change_evt,
    input  logic              unstable_rise,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      tx_byte,
    output logic              irq
);
    irq_vec_t   pend_q, en_q, set_v, pend_nxt;
    logic [W-1:0] tx_q, rd_q, rd_nxt;
    logic       clr;

    always_comb begin
        set_v.chg  = change_evt;
        set_v.unst = unstable_rise;
        clr        = rd_en && (reg_addr_e'(rd_addr) == A_STAT);
        pend_nxt   = (clr ? irq_vec_t'('0) : pend_q) | set_v;
        case (reg_addr_e'(rd_addr))
            A_TX:    rd_nxt = tx_q;
            A_ACC:   rd_nxt = accepted;
            A_STAT:  rd_nxt = W'({unstable, pend_q.unst, pend_q.chg});
            default: rd_nxt = W'({en_q.unst, en_q.chg});
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            tx_q   <= '0;
            rd_q   <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (rd_en)
                rd_q <= rd_nxt;
            if (wr_en) begin
                if (reg_addr_e'(wr_addr) == A_TX)
                    tx_q <= wr_data;
                else if (reg_addr_e'(wr_addr) == A_EN)
                    en_q <= irq_vec_t'(wr_data[1:0]);
            end
        end
    end

    assign rd_data = rd_q;
    assign tx_byte = tx_q;
    assign irq     = |(pend_q & en_q);

    // R4: change pending rises only from a change event
    p_chg_set_by_event_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.chg) |-> $past(change_evt))
        else $error("change pending without event");

    // R6: unstable pending rises only from a flag rise
    p_unst_set_by_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.unst) |-> $past(unstable_rise))
        else $error("unstable pending without rise");

    // R9: pending bits drop only through a status read
    p_clear_by_read_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(pend_q.chg) || $fell(pend_q.unst)) |->
            $past(rd_en && reg_addr_e'(rd_addr) == A_STAT))
        else $error("pending cleared without status read");

endmodule

// File: rtl/sync_status_monitor.sv
module sync_status_monitor
    import ssm_pkg::*;
#(
    parameter int PERSIST = 8,
    parameter int WIN     = 8,
    parameter int MIN_BAD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] accepted_byte,
    output logic              unstable,
    output logic [2:0]        qual_code,
    output logic              irq
);
    logic run_full, change_evt, unstable_rise;

    ssm_persist #(.W(BYTE_W), .PERSIST(PERSIST)) u_persist (
        .clk        (clk),
        .rst        (rst),
        .strobe     (frame_valid),
        .byte_in    (rx_byte),
        .accepted   (accepted_byte),
        .run_full   (run_full),
        .change_evt (change_evt)
    );

    ssm_window #(.W(BYTE_W), .WIN(WIN), .MIN_BAD(MIN_BAD)) u_window (
        .clk           (clk),
        .rst           (rst),
        .strobe        (frame_valid),
        .byte_in       (rx_byte),
        .ref_byte      (accepted_byte),
        .run_full      (run_full),
        .unstable      (unstable),
        .unstable_rise (unstable_rise)
    );

    ssm_regs #(.W(BYTE_W)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .accepted      (accepted_byte),
        .unstable      (unstable),
        .change_evt    (change_evt),
        .unstable_rise (unstable_rise),
        .rd_data       (rd_data),
        .tx_byte       (tx_byte),
        .irq           (irq)
    );

    assign qual_code = 3'(decode_quality(accepted_byte[3:0]));

    // R1: flag is high in the first cycle after reset
    p_reset_unstable_r1: assert property (@(posedge clk)
        $fell(rst) |-> (unstable && accepted_byte == '0 && !irq))
        else $error("bad reset state");

endmodule

// File: tb/sync_status_monitor_test.sv
`timescale 1ns/1ps
module sync_status_monitor_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data, tx_byte, accepted_byte;
    logic       unstable, irq;
    logic [2:0] qual_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_status_monitor uut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .rx_byte(rx_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_byte(tx_byte), .accepted_byte(accepted_byte),
        .unstable(unstable), .qual_code(qual_code), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] b);
        @(negedge clk);
        frame_valid = 1'b1;
        rx_byte     = b;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic frames(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) frame(b);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 accepted", accepted_byte, 8'h00);
        chk("R1 unstable", unstable, 1);
        chk("R1 irq", irq, 0);
        chk("R1 tx", tx_byte, 8'h00);
        chk("R12 qual 0000", qual_code, 2);
        rd(2'd2, d); chk("R1 status", d, 8'h04);
        rd(2'd3, d); chk("R1 enable", d, 8'h00);
    endtask

    task automatic t_accept();
        logic [7:0] d;
        frames(8'h01, 7);
        chk("R2 seven not enough", accepted_byte, 8'h00);
        chk("R7 still unstable", unstable, 1);
        frame(8'h01);
        chk("R2 accepted after eight", accepted_byte, 8'h01);
        chk("R12 qual 0001", qual_code, 1);
        chk("R7 cleared on new value", unstable, 0);
        chk("R10 masked irq", irq, 0);
        rd(2'd2, d); chk("R4 change pending", d, 8'h01);
        rd(2'd2, d); chk("R9 cleared by read", d, 8'h00);
    endtask

    task automatic t_unstable();
        logic [7:0] d;
        wr(2'd3, 8'h02);
        frames(8'h01, 3);
        frame(8'h0F);
        chk("R5 one mismatch", unstable, 0);
        frames(8'h01, 2);
        frame(8'h0F);
        chk("R5 two mismatches", unstable, 1);
        chk("R10 irq unstable", irq, 1);
        rd(2'd2, d); chk("R6 status", d, 8'h06);
        chk("R9 irq after read", irq, 0);
        frames(8'h01, 7);
        chk("R7 held at seven", unstable, 1);
        frame(8'h01);
        chk("R7 cleared same value", unstable, 0);
        chk("R7 accepted kept", accepted_byte, 8'h01);
    endtask

    task automatic t_restart();
        logic [7:0] d;
        wr(2'd3, 8'h03);
        frames(8'h0A, 7);
        chk("R6 unstable rose", unstable, 1);
        chk("R10 irq", irq, 1);
        frame(8'h07);
        frames(8'h0A, 7);
        chk("R3 run restarted", accepted_byte, 8'h01);
        frame(8'h0A);
        chk("R3 accepted after full run", accepted_byte, 8'h0A);
        chk("R12 qual 1010", qual_code, 4);
        chk("R7 cleared", unstable, 0);
        rd(2'd2, d); chk("R4 status both", d, 8'h03);
        chk("R9 irq cleared", irq, 0);
    endtask

    task automatic t_ignore();
        logic [7:0] d;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_byte = 8'(i * 37 + 5);
        end
        chk("R8 accepted held", accepted_byte, 8'h0A);
        chk("R8 unstable held", unstable, 0);
        rd(2'd2, d); chk("R8 no pending", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd0, 8'h0C);
        chk("R11 tx", tx_byte, 8'h0C);
        rd(2'd0, d); chk("R11 tx readback", d, 8'h0C);
        wr(2'd1, 8'h55);
        rd(2'd1, d); chk("R11 accepted read-only", d, 8'h0A);
        wr(2'd2, 8'h07);
        rd(2'd2, d); chk("R11 status write ignored", d, 8'h00);
    endtask

    task automatic t_quality(input logic [7:0] b, input logic [2:0] exp);
        logic [7:0] d;
        frames(b, 8);
        chk("R12 accepted", accepted_byte, b);
        chk("R12 qual", qual_code, exp);
        rd(2'd2, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_accept();
        t_unstable();
        t_restart();
        t_ignore();
        t_regs();
        t_quality(8'h3E, 3'd7);
        t_quality(8'h0C, 3'd5);
        t_quality(8'h0F, 3'd6);
        t_quality(8'h07, 3'd3);
        t_quality(8'h55, 3'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule